// File: doc/BRIEF.md
# Level Interrupt Controller with Reset-Switch Latch

This block collects 32 interrupt request lines and merges them into one interrupt to the processor. Each line has a cause bit and a mask bit. The two registers sit on a simple 32-bit register bus that has an address, a write enable, byte strobes, write data and combinational read data. Almost every line is level-sensitive. It passes through a two-flop synchronizer, and its cause bit follows the synchronized input. The bit falls by itself when the source lets go.

A reset push-button takes a different path. A press, seen as a rising edge after synchronization, sets a latched cause bit. That bit stays set until software writes 1 to it. A second cause bit shows the live button level. A write to a third register pulses a platform reset request. Software reads pending work as cause AND mask and services the lowest set bit first. A status output gives that lowest pending index directly.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0, the latched switch bit (cause bit 1) is 0, and irq_o and plat_rst_o are 0.
- R2: The mask register is at offset 0x04 and can be read and written. A write updates only the bytes whose strobe is set (be_i[k] covers bits 8k+7..8k).
- R3: The cause register is at offset 0x00. Each cause bit other than 1 and 16 equals src_i of the same index, delayed by two clock edges. The bit drops when the source drops. Writing 1 to these bits has no effect.
- R4: irq_o is the OR of (cause AND mask), with bit 16 excluded, registered once. It therefore follows a src_i change after three clock edges. Mask 0 keeps irq_o at 0.
- R5: Cause bit 1 is set by a rising edge of sw_press_i, seen after synchronization, and stays set after release. A write to offset 0x00 with be_i[0]=1 and wdata_i[1]=1 clears it. Without be_i[0] the bit stays set. src_i[1] is ignored.
- R6: Cause bit 16 reads 0 while sw_press_i is 1 (pressed) and 1 while it is 0, after the same two-edge delay. It never adds to pending or irq_o. src_i[16] is ignored.
- R7: Any write to offset 0x24, whatever the strobes, drives plat_rst_o high for exactly the one cycle after the write edge.
- R8: pend_vld_o is 1 exactly when cause AND mask, with bit 16 excluded, is nonzero. In that case pend_idx_o is the lowest set bit index.
- R9: A read of an unmapped offset, including 0x24, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level interrupt sources, asynchronous |
| sw_press_i | input | 1 | Reset button level, 1 = pressed, asynchronous |
| addr_i | input | AW | Register byte offset |
| we_i | input | 1 | Write enable |
| be_i | input | 4 | Byte strobes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | 1 | Combined processor interrupt |
| plat_rst_o | output | 1 | One-cycle platform reset request |
| pend_idx_o | output | 5 | Lowest pending source index |
| pend_vld_o | output | 1 | Some source is pending |

## Verification
A corrupt mask bit shows up on the next read of 0x04. It also shows up on irq_o and pend_idx_o one edge after the pattern that exposes it. A wrong synchronizer depth moves the cause bits and irq_o off the two-edge and three-edge timing. A stuck or lost switch latch shows up in cause bit 1 after release and after writes to the wrong strobe. A failed priority encoding shows up at once as a wrong pend_idx_o when several masked sources are high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW          = 32;
  localparam int NB          = DW / 8;
  localparam int IW          = $clog2(DW);
  localparam int SW_BIT      = 1;
  localparam int SW_LIVE_BIT = 16;
  localparam logic [7:0] OFF_CAUSE = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_PRST  = 8'h24;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_sw_latch.sv
module irq_sw_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q, rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= rise | (flag_q & ~clr_i);  // set wins over clear
    end
  end

  assign flag_o = flag_q;

  // R5: a press edge always latches
  a_r5_set_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> flag_o);
  // R5: only a clear can drop the latch
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        vld_o = 1'b1;
      end
    end
  end

  // R8: reported index is set and nothing below it is
  always_comb begin
    if (vld_o) begin
      a_r8_lowest: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end else begin
      a_r8_none: assert (req_i == '0);
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          sw_press_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          plat_rst_o,
  output logic [IW-1:0] pend_idx_o,
  output logic          pend_vld_o
);
  localparam logic [DW-1:0] PEND_EN = ~(DW'(1) << SW_LIVE_BIT);

  logic [DW-1:0] src_sync, cause, pend, mask_q;
  logic          sw_sync, sw_flag, sw_clr;
  logic          irq_q, prst_q;
  logic          sel_cause, sel_mask, sel_prst;
  logic          unused_src;

  assign sel_cause = (addr_i == AW'(OFF_CAUSE));
  assign sel_mask  = (addr_i == AW'(OFF_MASK));
  assign sel_prst  = (addr_i == AW'(OFF_PRST));

  irq_sync2 #(.W(DW + 1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sw_press_i, src_i}),
    .q_o    ({sw_sync, src_sync})
  );

  assign sw_clr = we_i && sel_cause && be_i[SW_BIT/8] && wdata_i[SW_BIT];

  irq_sw_latch u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sw_sync),
    .clr_i  (sw_clr),
    .flag_o (sw_flag)
  );

  assign unused_src = src_sync[SW_BIT] ^ src_sync[SW_LIVE_BIT];

  for (genvar i = 0; i < DW; i++) begin : g_cause
    if (i == SW_BIT) begin : g_latched
      assign cause[i] = sw_flag;
    end else if (i == SW_LIVE_BIT) begin : g_live
      assign cause[i] = ~sw_sync;
    end else begin : g_level
      assign cause[i] = src_sync[i];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[8*b +: 8] <= '0;
      else if (we_i && sel_mask && be_i[b]) mask_q[8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign pend = cause & mask_q & PEND_EN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      prst_q <= 1'b0;
    end else begin
      irq_q  <= |pend;
      prst_q <= we_i && sel_prst;
    end
  end

  irq_prio_enc #(.N(DW)) u_prio (
    .req_i (pend),
    .idx_o (pend_idx_o),
    .vld_o (pend_vld_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_cause)     rdata_o = cause;
    else if (sel_mask) rdata_o = mask_q;
  end

  assign irq_o      = irq_q;
  assign plat_rst_o = prst_q;

  // R4: no mask bits, no interrupt
  a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
  // R6: live switch bit never drives the interrupt alone
  a_r6_live_excluded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause & mask_q & PEND_EN) == '0) |=> !irq_o);
  // R7: reset request follows a write to its offset
  a_r7_prst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_prst) |=> plat_rst_o);
  a_r7_prst_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plat_rst_o |-> $past(we_i && sel_prst));
endmodule

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sw = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, prst, vld;
  logic [4:0]  idx;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  lvl_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sw_press_i(sw),
    .addr_i(addr), .we_i(we), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .plat_rst_o(prst), .pend_idx_o(idx), .pend_vld_o(vld)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_0220, 32'h0000_0220, 32'h8000_0000,
    32'h0001_0000, 32'h0000_0002, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0009};
  localparam logic [31:0] V_MSK [NV] = '{32'hFFFF_FFFF, 32'h0000_0200, 32'h8000_0000,
    32'h0001_0000, 32'h0000_0002, 32'h0000_0000, 32'h0001_0000, 32'h0000_0008};

  function automatic logic [31:0] exp_cause(logic [31:0] s, logic lat, logic pressed);
    logic [31:0] c;
    c = s;
    c[1]  = lat;
    c[16] = !pressed;
    return c;
  endfunction

  function automatic logic [31:0] exp_pend(logic [31:0] c, logic [31:0] m);
    logic [31:0] p;
    p = c & m;
    p[16] = 1'b0;
    return p;
  endfunction

  function automatic logic [4:0] low_idx(logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, c, p;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    rd(8'h04, d); chk("R1 mask", d, 32'h0);
    rd(8'h00, d); chk("R1 cause", d, exp_cause(32'h0, 1'b0, 1'b0));
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 prst", {31'd0, prst}, 32'd0);

    // table walk: R3 R4 R6 R8 and ignored src bit 1 (R5)
    for (int v = 0; v < NV; v++) begin
      wr(8'h04, V_MSK[v], 4'hF);
      @(negedge clk); src = V_SRC[v];
      wait_n(4);
      c = exp_cause(V_SRC[v], 1'b0, 1'b0);
      p = exp_pend(c, V_MSK[v]);
      chk("R4 irq", {31'd0, irq}, {31'd0, |p});
      chk("R8 vld", {31'd0, vld}, {31'd0, |p});
      if (|p) chk("R8 idx", {27'd0, idx}, {27'd0, low_idx(p)});
      rd(8'h00, d); chk("R3 R5 R6 cause", d, c);
    end

    // R4 timing: three edges from src change to irq
    wr(8'h04, 32'h0000_0100, 4'hF);
    @(negedge clk); src = 32'h0;
    wait_n(4);
    @(negedge clk); src = 32'h0000_0100;
    wait_n(2); chk("R4 early", {31'd0, irq}, 32'd0);
    wait_n(1); chk("R4 edge3", {31'd0, irq}, 32'd1);

    // R3 level drop and w1 no effect
    wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    rd(8'h00, d); chk("R3 w1 ignored", d, exp_cause(32'h0000_0100, 1'b0, 1'b0));
    @(negedge clk); src = 32'h0;
    wait_n(4);
    rd(8'h00, d); chk("R3 drop", d, exp_cause(32'h0, 1'b0, 1'b0));
    chk("R3 irq drop", {31'd0, irq}, 32'd0);

    // R2 byte strobes
    wr(8'h04, 32'h0, 4'hF);
    wr(8'h04, 32'hFFFF_FFFF, 4'b0101);
    rd(8'h04, d); chk("R2 strobes", d, 32'h00FF_00FF);

    // R5 R6 switch press/latch/clear
    wr(8'h04, 32'h0000_0002, 4'hF);
    @(negedge clk); sw = 1'b1;
    wait_n(4);
    rd(8'h00, d); chk("R5 R6 pressed", d, exp_cause(32'h0, 1'b1, 1'b1));
    chk("R5 irq", {31'd0, irq}, 32'd1);
    chk("R8 idx sw", {27'd0, idx}, 32'd1);
    @(negedge clk); sw = 1'b0;
    wait_n(4);
    rd(8'h00, d); chk("R5 held", d, exp_cause(32'h0, 1'b1, 1'b0));
    wr(8'h00, 32'h0000_0002, 4'b1110);
    rd(8'h00, d); chk("R5 no strobe", d, exp_cause(32'h0, 1'b1, 1'b0));
    wr(8'h00, 32'h0000_0002, 4'b0001);
    rd(8'h00, d); chk("R5 cleared", d, exp_cause(32'h0, 1'b0, 1'b0));
    wait_n(2); chk("R5 irq clr", {31'd0, irq}, 32'd0);

    // R7 reset request pulse, any strobe
    wr(8'h24, 32'h0, 4'h0);
    chk("R7 pulse", {31'd0, prst}, 32'd1);
    @(negedge clk); chk("R7 one cycle", {31'd0, prst}, 32'd0);

    // R9 unmapped reads
    rd(8'h24, d); chk("R9 prst read", d, 32'h0);
    rd(8'h10, d); chk("R9 unmapped", d, 32'h0);

    // R1 reset mid-run
    wr(8'h04, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h04, d); chk("R1 mask after reset", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule